// File: doc/BRIEF.md
# Time-of-Day Counter with Mains-Rate Time Base

This block keeps the time of day from a 60 Hz pulse train. The pulse input is first brought into the system clock domain. A two-state edge machine then turns each rising edge into a single-cycle count pulse. A divide-by-60 prescaler reduces those pulses to a once-per-second tick. That tick drives a seconds section, a minutes section and a 24-hour hours section, all connected in cascade. Each divide-by-60 section, the prescaler included, is a decade counter followed by a divide-by-6 counter. The seconds, minutes and hours values therefore appear directly as BCD tens and units digits, ready for a display decoder.

All state runs on the system clock. Carries between sections are clock-enable pulses, not derived clocks. A synchronous reset returns the time to 00:00:00 and clears the prescaler and the edge logic. The parameter `PRESCALE_EN` selects one of two variants. When it is 1, the prescaler is present. When it is 0, the prescaler is left out and every input edge counts as one second, which suits a time base that is already at 1 Hz.

The edge machine has two states. `EDGE_LOW` waits for the synchronised input to go high. On the transition to `EDGE_HIGH` it emits the count pulse. `EDGE_HIGH` waits for the input to return low. On that transition it goes back to `EDGE_LOW` and emits no pulse.

Top module: `timekeep_core`

## Requirements
- R1: Each rising edge of `line_in` is counted exactly once, however long the input stays high. A 0-to-1 change sampled at a clock edge becomes a count pulse two cycles later, through two synchroniser stages. An input that is high for only one cycle is still counted once.
- R2: With `PRESCALE_EN`=1, `sec_tick` is high for exactly one cycle in every 60 counted edges. It is high in the same cycle as the 60th count pulse, and the seconds value advances on the next clock edge.
- R3: The seconds digits are BCD. The units digit counts 0 to 9 and carries into the tens digit, which counts 0 to 5. The tens digit changes only when units wraps from 9.
- R4: The minutes digits advance by one only on the clock edge where seconds wrap from 59 to 00. They use the same units-then-tens BCD form.
- R5: The hours digits count 00 to 23 in BCD and advance when minutes wrap from 59. After 23:59:59 the time becomes 00:00:00.
- R6: While `rst` is high at a clock edge, all six digits become 0, the prescaler is cleared and the edge logic returns to `EDGE_LOW`. After reset with `PRESCALE_EN`=1, 60 more edges are needed before seconds reach 01.
- R7: No digit ever leaves its range. Seconds and minutes tens stay at most 5. Units digits stay at most 9. Hours stay at most 23.
- R8: With `PRESCALE_EN`=0, every counted edge advances seconds by one and `sec_tick` equals the count pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| line_in | input | 1 | 60 Hz pulse train, asynchronous to `clk` |
| sec_tick | output | 1 | One-cycle pulse when seconds are about to advance |
| hr_tens | output | 4 | Hours tens digit, BCD 0-2 |
| hr_units | output | 4 | Hours units digit, BCD 0-9 |
| min_tens | output | 4 | Minutes tens digit, BCD 0-5 |
| min_units | output | 4 | Minutes units digit, BCD 0-9 |
| sec_tens | output | 4 | Seconds tens digit, BCD 0-5 |
| sec_units | output | 4 | Seconds units digit, BCD 0-9 |

## Verification
Some properties are checked by the assertions on every cycle:
- each digit stays in range;
- a tens digit moves only after its units digit was 9;
- minutes move only after seconds showed 59;
- hours wrap from 23 to 00;
- reset clears the digits;
- a tick is always followed by a change in seconds.

Other behaviour only the bench scenarios can show:
- one count per edge, whatever the high time, including a one-cycle pulse;
- the exact 60-to-1 prescale ratio;
- the prescaler being cleared by a reset in mid-second;
- the full-day rollover of the bypass variant.

These are all compared against a model driven by the same input every cycle.

// File: rtl/tk_pkg.sv
package tk_pkg;
    localparam int DIGIT_W = 4;
    typedef logic [DIGIT_W-1:0] bcd_t;
    typedef enum logic {EDGE_LOW, EDGE_HIGH} edge_state_e;
endpackage

// File: rtl/tk_edge_detect.sv
module tk_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic pulse
);
    import tk_pkg::*;

    logic [SYNC_STAGES-1:0] sync_q;
    edge_state_e            state_q, state_d;
    logic                   level;

    assign level = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], async_in};
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= EDGE_LOW;
        else     state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EDGE_LOW:  if (level)  state_d = EDGE_HIGH;
            EDGE_HIGH: if (!level) state_d = EDGE_LOW;
        endcase
    end

    // outputs
    always_comb begin
        pulse = 1'b0;
        unique case (state_q)
            EDGE_LOW:  pulse = level;
            EDGE_HIGH: pulse = 1'b0;
        endcase
    end
endmodule

// File: rtl/tk_bcd_pair.sv
module tk_bcd_pair #(
    parameter int UNITS_LAST = 9,
    parameter int WRAP_TENS  = 5,
    parameter int WRAP_UNITS = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    output tk_pkg::bcd_t  units,
    output tk_pkg::bcd_t  tens,
    output logic          carry
);
    import tk_pkg::*;

    localparam bcd_t U_LAST = bcd_t'(UNITS_LAST);
    localparam bcd_t T_WRAP = bcd_t'(WRAP_TENS);
    localparam bcd_t U_WRAP = bcd_t'(WRAP_UNITS);

    logic at_wrap;
    assign at_wrap = (tens == T_WRAP) && (units == U_WRAP);
    assign carry   = en && at_wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            units <= '0;
            tens  <= '0;
        end else if (en) begin
            if (at_wrap) begin
                units <= '0;
                tens  <= '0;
            end else if (units == U_LAST) begin
                units <= '0;
                tens  <= tens + 1'b1;
            end else begin
                units <= units + 1'b1;
            end
        end
    end
endmodule

// File: rtl/timekeep_core.sv
module timekeep_core #(
    parameter int SYNC_STAGES = 2,
    parameter bit PRESCALE_EN = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       line_in,
    output logic       sec_tick,
    output logic [3:0] hr_tens,
    output logic [3:0] hr_units,
    output logic [3:0] min_tens,
    output logic [3:0] min_units,
    output logic [3:0] sec_tens,
    output logic [3:0] sec_units
);
    import tk_pkg::*;

    logic edge_pulse;
    logic sec_en, sec_carry, min_carry, hr_carry;

    tk_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst(rst), .async_in(line_in), .pulse(edge_pulse)
    );

    generate
        if (PRESCALE_EN) begin : g_pre
            bcd_t pre_u, pre_t;
            tk_bcd_pair #(.UNITS_LAST(9), .WRAP_TENS(5), .WRAP_UNITS(9)) u_pre (
                .clk(clk), .rst(rst), .en(edge_pulse),
                .units(pre_u), .tens(pre_t), .carry(sec_en)
            );
        end else begin : g_nopre
            assign sec_en = edge_pulse;
        end
    endgenerate

    assign sec_tick = sec_en;

    tk_bcd_pair #(.UNITS_LAST(9), .WRAP_TENS(5), .WRAP_UNITS(9)) u_sec (
        .clk(clk), .rst(rst), .en(sec_en),
        .units(sec_units), .tens(sec_tens), .carry(sec_carry)
    );

    tk_bcd_pair #(.UNITS_LAST(9), .WRAP_TENS(5), .WRAP_UNITS(9)) u_min (
        .clk(clk), .rst(rst), .en(sec_carry),
        .units(min_units), .tens(min_tens), .carry(min_carry)
    );

    tk_bcd_pair #(.UNITS_LAST(9), .WRAP_TENS(2), .WRAP_UNITS(3)) u_hr (
        .clk(clk), .rst(rst), .en(min_carry),
        .units(hr_units), .tens(hr_tens), .carry(hr_carry)
    );
endmodule

// File: rtl/timekeep_core_chk.sv
module timekeep_core_chk (
    input logic       clk,
    input logic       rst,
    input logic       sec_tick,
    input logic [3:0] hr_tens,
    input logic [3:0] hr_units,
    input logic [3:0] min_tens,
    input logic [3:0] min_units,
    input logic [3:0] sec_tens,
    input logic [3:0] sec_units
);
    a_r7_digit_range: assert property (@(posedge clk) disable iff (rst)
        sec_units <= 4'd9 && sec_tens <= 4'd5 && min_units <= 4'd9 &&
        min_tens <= 4'd5 && hr_units <= 4'd9 &&
        (hr_tens < 4'd2 || (hr_tens == 4'd2 && hr_units <= 4'd3)));

    a_r6_reset_clears: assert property (@(posedge clk)
        rst |=> (hr_tens == 0 && hr_units == 0 && min_tens == 0 &&
                 min_units == 0 && sec_tens == 0 && sec_units == 0));

    a_r3_tens_after_nine: assert property (@(posedge clk) disable iff (rst)
        (sec_tens != $past(sec_tens)) |-> ($past(sec_units) == 4'd9 || $past(rst)));

    a_r4_min_after_59: assert property (@(posedge clk) disable iff (rst)
        (min_units != $past(min_units)) |->
            (($past(sec_tens) == 4'd5 && $past(sec_units) == 4'd9) || $past(rst)));

    a_r5_hour_wrap: assert property (@(posedge clk) disable iff (rst)
        ($past(hr_tens) == 4'd2 && $past(hr_units) == 4'd3 && hr_units != $past(hr_units))
            |-> (hr_tens == 4'd0 && hr_units == 4'd0));

    a_r2_tick_moves_sec: assert property (@(posedge clk) disable iff (rst)
        sec_tick |=> (sec_units != $past(sec_units)));
endmodule

bind timekeep_core timekeep_core_chk u_chk (
    .clk(clk), .rst(rst), .sec_tick(sec_tick),
    .hr_tens(hr_tens), .hr_units(hr_units),
    .min_tens(min_tens), .min_units(min_units),
    .sec_tens(sec_tens), .sec_units(sec_units)
);

// File: tb/timekeep_core_bench.sv
module timekeep_core_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_in = 1'b0;

    always #2.5 clk = ~clk;

    logic       tick_a, tick_b;
    logic [3:0] ht_a, hu_a, mt_a, mu_a, st_a, su_a;
    logic [3:0] ht_b, hu_b, mt_b, mu_b, st_b, su_b;

    timekeep_core u_timekeep_core (
        .clk(clk), .rst(rst), .line_in(line_in), .sec_tick(tick_a),
        .hr_tens(ht_a), .hr_units(hu_a), .min_tens(mt_a), .min_units(mu_a),
        .sec_tens(st_a), .sec_units(su_a)
    );

    timekeep_core #(.PRESCALE_EN(1'b0)) u_fast (
        .clk(clk), .rst(rst), .line_in(line_in), .sec_tick(tick_b),
        .hr_tens(ht_b), .hr_units(hu_b), .min_tens(mt_b), .min_units(mu_b),
        .sec_tens(st_b), .sec_units(su_b)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // behavioural model state
    int m_meta = 0, m_sync = 0, m_prev = 0;
    int edges  = 0;

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int hms(input int s);
        return ((s / 3600) % 24) * 10000 + ((s / 60) % 60) * 100 + (s % 60);
    endfunction

    task automatic compare();
        int pulse_now, sa, sb, va, vb;
        pulse_now = (m_sync != 0 && m_prev == 0) ? 1 : 0;
        sa = edges / 60;
        sb = edges;
        va = hms(sa); vb = hms(sb);
        check("R3 seconds",  st_a * 10 + su_a, va % 100);
        check("R4 minutes",  mt_a * 10 + mu_a, (va / 100) % 100);
        check("R5 hours",    ht_a * 10 + hu_a, va / 10000);
        check("R2 sec_tick", int'(tick_a), (pulse_now != 0 && edges % 60 == 59) ? 1 : 0);
        check("R8 bypass time", ht_b * 10000 + hu_b * 1000 + mt_b * 100 + mu_b * 10 + st_b * 0 + 0,
              (vb / 10000) * 1000 + ((vb / 100) % 100) * 10);
        check("R8 bypass seconds", st_b * 10 + su_b, vb % 100);
        check("R8 bypass tick", int'(tick_b), pulse_now);
    endtask

    task automatic cyc(input logic v, input logic r);
        line_in = v;
        rst     = r;
        @(posedge clk);
        if (r) begin
            m_meta = 0; m_sync = 0; m_prev = 0; edges = 0;
        end else begin
            if (m_sync != 0 && m_prev == 0) edges++;
            m_prev = m_sync;
            m_sync = m_meta;
            m_meta = int'(v);
        end
        @(negedge clk);
        compare();
    endtask

    task automatic toggles(input int n);
        for (int i = 0; i < n; i++) begin
            cyc(1'b1, 1'b0);
            cyc(1'b0, 1'b0);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        @(negedge clk);
        for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1);
        // R6 reset state
        check("R6 reset digits", ht_a + hu_a + mt_a + mu_a + st_a + su_a, 0);
        // R1 long high level counts once
        for (int i = 0; i < 20; i++) cyc(1'b1, 1'b0);
        check("R1 long high one edge", st_b * 10 + su_b, 1);
        for (int i = 0; i < 10; i++) cyc(1'b0, 1'b0);
        // R1 single-cycle high counts once
        cyc(1'b1, 1'b0);
        for (int i = 0; i < 6; i++) cyc(1'b0, 1'b0);
        check("R1 one-cycle pulse", st_b * 10 + su_b, 2);
        // R2/R3/R4 run past one minute on the prescaled instance
        toggles(60 * 61 + 30);
        check("R4 minute reached", mt_a * 10 + mu_a, 1);
        // R6 mid-run reset clears prescaler
        toggles(25);
        cyc(1'b0, 1'b1);
        cyc(1'b0, 1'b1);
        check("R6 mid reset", ht_a + hu_a + mt_a + mu_a + st_a + su_a, 0);
        toggles(59);
        cyc(1'b0, 1'b0); cyc(1'b0, 1'b0);
        check("R6 prescaler cleared", st_a * 10 + su_a, 0);
        toggles(1);
        cyc(1'b0, 1'b0); cyc(1'b0, 1'b0);
        check("R2 first second", st_a * 10 + su_a, 1);
        // R5 full-day rollover on the bypass instance
        toggles(86400 - edges + 3);
        cyc(1'b0, 1'b0); cyc(1'b0, 1'b0);
        check("R5 day rollover", ht_b * 10000 + hu_b * 1000 + mt_b * 100 + mu_b * 10 + st_b * 10 + su_b, 3);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 198000; i++) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end
endmodule